// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block arbitrates among eleven maskable interrupt sources on behalf of a CPU. Each source carries a per-source enable and one priority bit that places it on the high or the low level. A global enable gates every new call. Every machine cycle (one clock here) the controller captures the raw request flags into a sample register. In the following cycle it evaluates those samples against the enables, the priority bits and the levels currently in service.

When a request is allowed, the controller raises a one-cycle call request with a fixed vector address. The CPU is expected to save only its program counter and jump to that address. In the same cycle the controller pulses an acknowledge bit for the winning source, so that the source can drop its flag. A return pulse from the CPU ends the newest active handler level. Nesting is legal only from low into high.

Software reaches four 8-bit registers through a simple write strobe and a combinational read port. Two of them hold the priority bits and two hold the enable bits, with the global enable in the top bit of the first enable register.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After hardware reset all four registers read 0, `call_req` is 0 and `in_service` is 2'b00.
- R2: Register address 0 holds the priority bits of sources 0,1,2,3 in bits 0,1,3,4, and bits 2,5,6,7 read 0. Address 1 holds sources 4..10 in bits 0..6, and bit 7 reads 0. Addresses 2 and 3 hold the enable bits in the same layout, except that bit 7 of address 2 is the global enable. A priority bit of 1 means high level.
- R3: A flag present before clock edge k produces `call_req` high after edge k+1, for exactly one cycle.
- R4: With `call_req`, `call_vec` equals 3 + 8 × source index and `call_ack` is one-hot on the winning source.
- R5: When high-level and low-level requests are both eligible in the same poll, a high-level source wins.
- R6: Among eligible requests of the same level, the lowest source index wins.
- R7: A source whose enable bit is 0 is never called. While the global enable is 0 no call is made, but pending flags stay pending and are called once the enable returns.
- R8: While only the low level is in service, no low-level source is called, and a high-level source is called (`in_service` becomes 2'b11).
- R9: While the high level is in service, no source is called.
- R10: A `reti` pulse clears the in-service bit of the highest active level only. From 2'b11 the result is 2'b01.
- R11: A `reti` and a new call in the same cycle both take effect: from 2'b01 with a high call, the result is 2'b10.
- R12: A `bus_rst` cycle clears the priority and enable registers, the in-service state and the sample stage, and no call follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Synchronous reset from the bus side, active high |
| irq_flag | input | 11 | Raw request flags, one per source |
| reti | input | 1 | Return-from-interrupt pulse from the CPU |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| call_req | output | 1 | One-cycle request to the CPU to save PC and jump |
| call_vec | output | 16 | Vector address for the call |
| call_ack | output | 11 | One-hot acknowledge to the winning source |
| in_service | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
A return pulse and a new call can both land on the same clock edge. The bench provokes this by holding a low-level handler in service, raising a high-level flag one cycle ahead, and driving `reti` in the very cycle that the sampled flag is polled. It judges the result from the call outputs and `in_service` on that edge: the call must be issued and the low level must be retired, leaving only the high bit set. Preemption from the low level, blocking under the high level and the ordering of pending work after a return are each checked on the exact cycle predicted by the two-stage sample-then-poll timing.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
   // Number of sources the register layout maps
   localparam int unsigned MAP_SRC = 11;
   localparam int unsigned MAP_RW  = 8;
   localparam int unsigned GIE_BIT = 7;

   typedef enum logic [1:0] {
      RA_PRIO_A = 2'd0,
      RA_PRIO_B = 2'd1,
      RA_EN_A   = 2'd2,
      RA_EN_B   = 2'd3
   } reg_addr_e;

   // Which of the two register pairs holds a source (0: A, 1: B)
   function automatic int unsigned src_bank(int unsigned i);
      return (i < 4) ? 0 : 1;
   endfunction

   // Bit position of a source inside its register
   function automatic int unsigned src_pos(int unsigned i);
      if (i < 2)      return i;
      else if (i < 4) return i + 1;
      else            return i - 4;
   endfunction
endpackage

// File: rtl/nest_irq_regs.sv
module nest_irq_regs
   import nest_irq_pkg::*;
#(
   parameter int unsigned N_SRC = 11,
   parameter int unsigned RW    = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [RW-1:0]    wr_data,
   input  logic [1:0]       rd_addr,
   output logic [RW-1:0]    rd_data,
   output logic [N_SRC-1:0] prio,
   output logic [N_SRC-1:0] en,
   output logic             gie
);
   logic [N_SRC-1:0] prio_q, en_q;
   logic             gie_q;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      localparam logic [1:0] PA = 2'(src_bank(g));
      localparam logic [1:0] EA = 2'(2 + src_bank(g));
      localparam int unsigned BP = src_pos(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[g] <= 1'b0;
            en_q[g]   <= 1'b0;
         end else if (bus_rst) begin
            prio_q[g] <= 1'b0;
            en_q[g]   <= 1'b0;
         end else if (wr_en) begin
            if (wr_addr == PA) prio_q[g] <= wr_data[BP];
            if (wr_addr == EA) en_q[g]   <= wr_data[BP];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 gie_q <= 1'b0;
      else if (bus_rst)                           gie_q <= 1'b0;
      else if (wr_en && wr_addr == RA_EN_A)       gie_q <= wr_data[GIE_BIT];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (rd_addr == 2'(src_bank(i)))     rd_data[src_pos(i)] = prio_q[i];
         if (rd_addr == 2'(2 + src_bank(i))) rd_data[src_pos(i)] = en_q[i];
      end
      if (rd_addr == RA_EN_A) rd_data[GIE_BIT] = gie_q;
   end

   assign prio = prio_q;
   assign en   = en_q;
   assign gie  = gie_q;

   // R2: unused bits of the first priority register never read as 1
   p_rsvd_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_PRIO_A) |-> (rd_data[2] == 1'b0 && rd_data[7:5] == 3'b000));
   // R2: top bit of the second priority register never reads as 1
   p_rsvd_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == RA_PRIO_B) |-> (rd_data[7] == 1'b0));
endmodule

// File: rtl/nest_irq_sampler.sv
module nest_irq_sampler #(
   parameter int unsigned N_SRC = 11
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic [N_SRC-1:0] flag_in,
   output logic [N_SRC-1:0] flag_smp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_smp <= '0;
      else if (bus_rst) flag_smp <= '0;
      else              flag_smp <= flag_in;
   end
endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb #(
   parameter int unsigned N_SRC           = 11,
   parameter int unsigned VEC_W           = 16,
   parameter int unsigned VEC_BASE        = 3,
   parameter int unsigned VEC_STEP        = 8,
   parameter bit          LOW_INDEX_FIRST = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic [N_SRC-1:0] smp,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] prio,
   input  logic             gie,
   input  logic             reti,
   output logic             call_req,
   output logic             call_hi,
   output logic [VEC_W-1:0] call_vec,
   output logic [N_SRC-1:0] call_ack,
   output logic [1:0]       isr_q
);
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   logic [N_SRC-1:0] elig, hi_c, lo_c, pick;
   logic             go_hi, go_lo, grant;
   logic [IDX_W-1:0] idx;
   logic [1:0]       clr, set, isr_n;

   assign elig  = smp & en & {N_SRC{gie}};
   assign hi_c  = elig & prio;
   assign lo_c  = elig & ~prio;
   assign go_hi = (|hi_c) && !isr_q[1];
   assign go_lo = !(|hi_c) && (|lo_c) && (isr_q == 2'b00);
   assign grant = go_hi | go_lo;
   assign pick  = go_hi ? hi_c : lo_c;

   if (LOW_INDEX_FIRST) begin : g_scan_up
      always_comb begin
         idx = '0;
         for (int i = N_SRC - 1; i >= 0; i--)
            if (pick[i]) idx = IDX_W'(i);
      end
   end else begin : g_scan_down
      always_comb begin
         idx = '0;
         for (int i = 0; i < N_SRC; i++)
            if (pick[i]) idx = IDX_W'(i);
      end
   end

   always_comb begin
      clr = 2'b00;
      if (reti) clr = isr_q[1] ? 2'b10 : 2'b01;
      set = 2'b00;
      if (grant) set = go_hi ? 2'b10 : 2'b01;
      isr_n = (isr_q & ~clr) | set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q    <= 2'b00;
         call_req <= 1'b0;
         call_hi  <= 1'b0;
         call_vec <= '0;
         call_ack <= '0;
      end else if (bus_rst) begin
         isr_q    <= 2'b00;
         call_req <= 1'b0;
         call_hi  <= 1'b0;
         call_vec <= '0;
         call_ack <= '0;
      end else begin
         isr_q    <= isr_n;
         call_req <= grant;
         call_hi  <= go_hi;
         call_vec <= grant ? VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx) : '0;
         call_ack <= '0;
         if (grant) call_ack[idx] <= 1'b1;
      end
   end

   // R4: a call acknowledges exactly one source
   p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
      call_req |-> ($countones(call_ack) == 1));
   // R9: high level in service blocks every call
   p_hi_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
      isr_q[1] |=> !call_req);
   // R8: under a low handler only a high-level call may follow
   p_lo_no_nest_r8: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
      (isr_q == 2'b01) |=> (!call_req || call_hi));
   // R10: return from nested state retires the high level only
   p_reti_top_r10: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
      (reti && isr_q == 2'b11) |=> (isr_q == 2'b01));
   // R7: global enable low means no call on the next edge
   p_gie_block_r7: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
      !gie |=> !call_req);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nest_irq_pkg::*;
#(
   parameter int unsigned N_SRC           = 11,
   parameter int unsigned RW              = 8,
   parameter int unsigned VEC_W           = 16,
   parameter int unsigned VEC_BASE        = 3,
   parameter int unsigned VEC_STEP        = 8,
   parameter bit          LOW_INDEX_FIRST = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic [N_SRC-1:0] irq_flag,
   input  logic             reti,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [RW-1:0]    wr_data,
   input  logic [1:0]       rd_addr,
   output logic [RW-1:0]    rd_data,
   output logic             call_req,
   output logic [VEC_W-1:0] call_vec,
   output logic [N_SRC-1:0] call_ack,
   output logic [1:0]       in_service
);
   localparam longint unsigned VEC_TOP = longint'(VEC_BASE) + longint'(VEC_STEP) * longint'(N_SRC - 1);

   if (N_SRC != MAP_SRC) begin : g_bad_nsrc
      $error("N_SRC must match the register layout");
   end
   if (RW != MAP_RW) begin : g_bad_rw
      $error("RW must be 8");
   end
   if (VEC_TOP >= (longint'(1) << VEC_W)) begin : g_bad_vec
      $error("VEC_W too narrow for the last vector");
   end

   logic [N_SRC-1:0] prio, en, smp;
   logic             gie, call_hi;

   nest_irq_regs #(.N_SRC(N_SRC), .RW(RW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .prio(prio), .en(en), .gie(gie)
   );

   nest_irq_sampler #(.N_SRC(N_SRC)) u_smp (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .flag_in(irq_flag), .flag_smp(smp)
   );

   nest_irq_arb #(
      .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
      .VEC_STEP(VEC_STEP), .LOW_INDEX_FIRST(LOW_INDEX_FIRST)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .smp(smp), .en(en), .prio(prio), .gie(gie), .reti(reti),
      .call_req(call_req), .call_hi(call_hi), .call_vec(call_vec),
      .call_ack(call_ack), .isr_q(in_service)
   );
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
   localparam int CLK_P = 10;
   localparam int NS    = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_rst = 1'b0;
   logic [NS-1:0] irq_flag = '0;
   logic          reti = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [7:0]    rd_data;
   logic          call_req;
   logic [15:0]   call_vec;
   logic [NS-1:0] call_ack;
   logic [1:0]    in_service;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   nest_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .irq_flag(irq_flag),
      .reti(reti), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .call_req(call_req),
      .call_vec(call_vec), .call_ack(call_ack), .in_service(in_service)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wreg(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rreg(logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      tick();
      reti = 1'b0;
   endtask

   task automatic expect_call(int src, string tag);
      chk(call_req === 1'b1, tag, 32'(call_req), 32'd1);
      chk(call_vec === 16'(3 + 8 * src), {tag, " vec"}, 32'(call_vec), 32'(3 + 8 * src));
      chk(call_ack === NS'(1 << src), {tag, " ack"}, 32'(call_ack), 32'(1 << src));
      irq_flag[src] = 1'b0;
   endtask

   task automatic expect_idle(int cycles, string tag);
      for (int i = 0; i < cycles; i++) begin
         tick();
         chk(call_req === 1'b0, tag, 32'(call_req), 32'd0);
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         rreg(2'(a), d);
         chk(d === 8'h00, "R1 reg reset", 32'(d), 32'h0);
      end
      chk(call_req === 1'b0, "R1 call idle", 32'(call_req), 32'd0);
      chk(in_service === 2'b00, "R1 in_service", 32'(in_service), 32'd0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wreg(2'd0, 8'hFF); rreg(2'd0, d);
      chk(d === 8'h1B, "R2 prio A", 32'(d), 32'h1B);
      wreg(2'd1, 8'hFF); rreg(2'd1, d);
      chk(d === 8'h7F, "R2 prio B", 32'(d), 32'h7F);
      wreg(2'd2, 8'hFF); rreg(2'd2, d);
      chk(d === 8'h9B, "R2 enable A", 32'(d), 32'h9B);
      wreg(2'd3, 8'hFF); rreg(2'd3, d);
      chk(d === 8'h7F, "R2 enable B", 32'(d), 32'h7F);
      wreg(2'd0, 8'h00);
      wreg(2'd1, 8'h00);
   endtask

   task automatic t_latency();
      irq_flag[5] = 1'b1;
      tick();
      chk(call_req === 1'b0, "R3 not after first edge", 32'(call_req), 32'd0);
      tick();
      expect_call(5, "R3 R4 call src5");
      tick();
      chk(call_req === 1'b0, "R3 single pulse", 32'(call_req), 32'd0);
      chk(in_service === 2'b01, "R3 low in service", 32'(in_service), 32'd1);
      do_reti();
      chk(in_service === 2'b00, "R10 low retired", 32'(in_service), 32'd0);
   endtask

   task automatic t_same_level();
      irq_flag[7] = 1'b1; irq_flag[4] = 1'b1;
      tick(); tick();
      expect_call(4, "R6 lowest index wins");
      expect_idle(3, "R8 low blocks low");
      reti = 1'b1;
      tick();
      reti = 1'b0;
      chk(call_req === 1'b0, "R6 no call on reti edge", 32'(call_req), 32'd0);
      tick();
      expect_call(7, "R6 pending low after reti");
      do_reti();
   endtask

   task automatic t_nesting();
      wreg(2'd0, 8'h08); // source 2 high via bit 3
      irq_flag[0] = 1'b1; irq_flag[2] = 1'b1;
      tick(); tick();
      expect_call(2, "R5 high beats low");
      tick();
      chk(in_service === 2'b10, "R5 high in service", 32'(in_service), 32'd2);
      irq_flag[2] = 1'b1;
      expect_idle(3, "R9 high blocks all");
      irq_flag[2] = 1'b0;
      tick();
      reti = 1'b1;
      tick();
      reti = 1'b0;
      chk(in_service === 2'b00, "R10 high retired", 32'(in_service), 32'd0);
      tick();
      expect_call(0, "R5 low after high");
      irq_flag[1] = 1'b1;
      expect_idle(3, "R8 low blocks second low");
      irq_flag[2] = 1'b1;
      tick(); tick();
      expect_call(2, "R8 high preempts low");
      tick();
      chk(in_service === 2'b11, "R8 nested", 32'(in_service), 32'd3);
      do_reti();
      chk(in_service === 2'b01, "R10 only high cleared", 32'(in_service), 32'd1);
      expect_idle(2, "R10 low still blocks");
      do_reti();
      chk(in_service === 2'b00, "R10 low cleared", 32'(in_service), 32'd0);
      tick();
      expect_call(1, "R6 pending low taken");
   endtask

   task automatic t_same_cycle();
      // low level in service from source 1
      tick();
      chk(in_service === 2'b01, "R11 setup", 32'(in_service), 32'd1);
      irq_flag[2] = 1'b1;
      tick();
      reti = 1'b1;
      tick();
      reti = 1'b0;
      expect_call(2, "R11 call with reti");
      chk(in_service === 2'b10, "R11 both applied", 32'(in_service), 32'd2);
      do_reti();
      chk(in_service === 2'b00, "R11 cleared", 32'(in_service), 32'd0);
   endtask

   task automatic t_enables();
      wreg(2'd2, 8'h8B); // source 3 (bit 4) disabled
      irq_flag[3] = 1'b1;
      expect_idle(4, "R7 disabled source");
      wreg(2'd2, 8'h1B); // all enabled, global off
      expect_idle(4, "R7 global off");
      wreg(2'd2, 8'h9B);
      chk(call_req === 1'b0, "R7 one poll after enable", 32'(call_req), 32'd0);
      tick();
      expect_call(3, "R7 pending kept");
      do_reti();
   endtask

   task automatic t_bus_reset();
      logic [7:0] d;
      wreg(2'd1, 8'hFF);
      irq_flag[4] = 1'b1;
      tick(); tick();
      expect_call(4, "R12 setup call");
      tick();
      chk(in_service === 2'b10, "R12 setup high", 32'(in_service), 32'd2);
      irq_flag[6] = 1'b1;
      do_reti();
      bus_rst = 1'b1; irq_flag[6] = 1'b0;
      tick();
      bus_rst = 1'b0;
      rreg(2'd1, d);
      chk(d === 8'h00, "R12 prio cleared", 32'(d), 32'h0);
      rreg(2'd2, d);
      chk(d === 8'h00, "R12 enable cleared", 32'(d), 32'h0);
      chk(in_service === 2'b00, "R12 in_service cleared", 32'(in_service), 32'd0);
      chk(call_req === 1'b0, "R12 no call at reset", 32'(call_req), 32'd0);
      expect_idle(3, "R12 no call after");
   endtask

   initial begin
      logic [7:0] d;
      #(CLK_P * 2 + 1);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_regs();
      t_latency();
      t_same_level();
      t_nesting();
      t_same_cycle();
      t_enables();
      t_bus_reset();
      rreg(2'd0, d);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule